// File: doc/BRIEF.md
# Accumulator Register-Reference Execution Unit

This block owns the 16-bit accumulator of a small single-accumulator machine together with its one-bit extension flag, and it performs every operation that touches only those two registers. The sequencer presents a 12-bit operation field in which each bit selects one action: clearing or complementing either register, rotating the accumulator through the extension flag in either direction, incrementing, testing a condition, or halting. Condition tests do not change any register. They raise a skip pulse that the program counter logic uses to step over the next instruction. The halt bit clears a start-stop flag.

The memory-reference sequencer reuses the same accumulator through a second strobe that carries an operand from the data register. That strobe selects AND, ADD (the carry goes into the extension flag) or load. Two character-port strobes complete the set. One writes an 8-bit input character into the low byte of the accumulator. The other copies the low byte into an 8-bit output register.

Top module: `accRegExec`

## Requirements
- R1: A synchronous reset, active high, sets the accumulator, the extension flag and the output character to zero and sets `running` to 1. During reset and while no strobe is high, `skipReq` and `haltReq` stay 0.
- R2: With `opStrobe` high, the clock edge applies the action of the selected bit. Bit 11 clears the accumulator. Bit 10 clears the flag. Bit 9 inverts the accumulator. Bit 8 inverts the flag. Bit 5 adds one to the accumulator modulo 2^16 and leaves the flag unchanged.
- R3: Bit 7 rotates right through the flag: the new accumulator is {flag, acc[15:1]} and the new flag is acc[0].
- R4: Bit 6 rotates left through the flag: the new accumulator is {acc[14:0], flag} and the new flag is acc[15].
- R5: Bits 4, 3, 2 and 1 raise `skipReq` combinationally in the strobe cycle when, respectively, acc[15] is 0, acc[15] is 1, the accumulator is zero, or the flag is 0. A test leaves both registers unchanged.
- R6: Bit 0 raises `haltReq` combinationally in the strobe cycle. From the next edge `running` is 0, and it stays 0 until reset. Other operations still execute while halted.
- R7: When several bits of `opField` are set, only the highest-numbered set bit acts. An all-zero field with `opStrobe` high changes nothing and raises no pulse.
- R8: With `memStrobe` high, `memOp` selects the operation on `drData`. Code 0 gives acc AND data. Code 1 gives a 17-bit sum: the low 16 bits go to the accumulator and the carry goes to the flag. Code 2 loads the data. Code 3 changes nothing.
- R9: `inStrobe` replaces acc[7:0] with `inChar` and keeps acc[15:8] and the flag.
- R10: `outStrobe` loads acc[7:0] into `outChar` and leaves the accumulator and the flag unchanged. `outChar` holds its value at all other times.
- R11: Only one strobe class acts per cycle. The order is `opStrobe`, then `memStrobe`, then `inStrobe`, then `outStrobe`. A lower strobe that is high at the same time as a higher one has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opStrobe | input | 1 | Execute the register-reference field this cycle |
| opField | input | 12 | One-hot operation bits, bit 11 down to bit 0 |
| memStrobe | input | 1 | Execute a data-register operation this cycle |
| memOp | input | 2 | 0 AND, 1 ADD, 2 load, 3 none |
| drData | input | 16 | Operand from the data register |
| inStrobe | input | 1 | Write input character into the low byte |
| inChar | input | 8 | Input character |
| outStrobe | input | 1 | Copy the low byte to the output register |
| acOut | output | 16 | Accumulator value |
| eOut | output | 1 | Extension flag |
| outChar | output | 8 | Output character register |
| skipReq | output | 1 | Skip pulse toward the program counter |
| haltReq | output | 1 | Halt pulse toward the start-stop flag |
| running | output | 1 | Start-stop flag, 1 while running |

## Verification
A wrong accumulator or flag bit shows at `acOut` or `eOut` one edge after the operation that produced it. A wrong register value also corrupts later condition tests, so the error surfaces again in `skipReq` during the cycle of those tests. Wrong priority decoding is caught in the same cycle: the bench drives multi-bit fields and overlapping strobes and watches for the wrong pulse. The next edge then shows the wrong register update. A lost halt shows up as `running` staying high one edge after a bit-0 operation.

// File: rtl/accRegPkg.sv
package accRegPkg;
  typedef struct packed {
    logic clrAc;
    logic clrE;
    logic cmaAc;
    logic cmeE;
    logic cirR;
    logic cirL;
    logic incAc;
    logic andOp;
    logic addOp;
    logic ldOp;
    logic inpOp;
    logic outOp;
    logic halt;
  } accCtlT;
endpackage

// File: rtl/accRegCtrl.sv
module accRegCtrl
  import accRegPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OPS_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              opStrobe,
  input  logic [OPS_W-1:0]  opField,
  input  logic              memStrobe,
  input  logic [1:0]        memOp,
  input  logic              inStrobe,
  input  logic              outStrobe,
  input  logic [DATA_W-1:0] acVal,
  input  logic              eVal,
  output accCtlT            ctl,
  output logic              skipReq,
  output logic              haltReq
);
  localparam int MSB = DATA_W - 1;

  int   hiIdx;
  logic hiHit;

  // Priority pick: a later (higher) set bit overrides an earlier one.
  always_comb begin
    hiIdx = 0;
    hiHit = 1'b0;
    for (int i = 0; i < OPS_W; i++) begin
      if (opField[i]) begin
        hiIdx = i;
        hiHit = 1'b1;
      end
    end
  end

  always_comb begin
    ctl     = '0;
    skipReq = 1'b0;
    if (opStrobe) begin
      if (hiHit) begin
        case (hiIdx)
          11: ctl.clrAc = 1'b1;
          10: ctl.clrE  = 1'b1;
          9:  ctl.cmaAc = 1'b1;
          8:  ctl.cmeE  = 1'b1;
          7:  ctl.cirR  = 1'b1;
          6:  ctl.cirL  = 1'b1;
          5:  ctl.incAc = 1'b1;
          4:  skipReq   = ~acVal[MSB];
          3:  skipReq   = acVal[MSB];
          2:  skipReq   = (acVal == '0);
          1:  skipReq   = ~eVal;
          0:  ctl.halt  = 1'b1;
          default: ;
        endcase
      end
    end else if (memStrobe) begin
      case (memOp)
        2'd0: ctl.andOp = 1'b1;
        2'd1: ctl.addOp = 1'b1;
        2'd2: ctl.ldOp  = 1'b1;
        default: ;
      endcase
    end else if (inStrobe) begin
      ctl.inpOp = 1'b1;
    end else if (outStrobe) begin
      ctl.outOp = 1'b1;
    end
  end

  assign haltReq = ctl.halt;

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctl)) else $error("more than one action");  // R11
  AST_SKIP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !opStrobe |-> !skipReq && !haltReq) else $error("pulse without strobe");  // R5
  AST_LOW_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    opStrobe |-> !(ctl.andOp || ctl.addOp || ctl.ldOp || ctl.inpOp || ctl.outOp))
    else $error("lower strobe acted");  // R11
endmodule

// File: rtl/accRegData.sv
module accRegData
  import accRegPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  accCtlT            ctl,
  input  logic [DATA_W-1:0] drData,
  input  logic [CHAR_W-1:0] inChar,
  output logic [DATA_W-1:0] acReg,
  output logic              eReg,
  output logic [CHAR_W-1:0] outReg,
  output logic              runReg
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] sumFull;
  assign sumFull = {1'b0, acReg} + {1'b0, drData};

  always_ff @(posedge clk) begin
    if (rst) begin
      acReg  <= '0;
      eReg   <= 1'b0;
      outReg <= '0;
      runReg <= 1'b1;
    end else begin
      if (ctl.clrAc)      acReg <= '0;
      else if (ctl.cmaAc) acReg <= ~acReg;
      else if (ctl.incAc) acReg <= acReg + 1'b1;
      else if (ctl.cirR)  acReg <= {eReg, acReg[MSB:1]};
      else if (ctl.cirL)  acReg <= {acReg[MSB-1:0], eReg};
      else if (ctl.andOp) acReg <= acReg & drData;
      else if (ctl.addOp) acReg <= sumFull[MSB:0];
      else if (ctl.ldOp)  acReg <= drData;
      else if (ctl.inpOp) acReg <= {acReg[MSB:CHAR_W], inChar};

      if (ctl.clrE)       eReg <= 1'b0;
      else if (ctl.cmeE)  eReg <= ~eReg;
      else if (ctl.cirR)  eReg <= acReg[0];
      else if (ctl.cirL)  eReg <= acReg[MSB];
      else if (ctl.addOp) eReg <= sumFull[DATA_W];

      if (ctl.outOp) outReg <= acReg[CHAR_W-1:0];
      if (ctl.halt)  runReg <= 1'b0;
    end
  end

  AST_CIR_RIGHT: assert property (@(posedge clk) disable iff (rst)
    ctl.cirR |=> acReg == {$past(eReg), $past(acReg[MSB:1])} && eReg == $past(acReg[0]))
    else $error("rotate right wrong");  // R3
  AST_CIR_LEFT: assert property (@(posedge clk) disable iff (rst)
    ctl.cirL |=> acReg == {$past(acReg[MSB-1:0]), $past(eReg)} && eReg == $past(acReg[MSB]))
    else $error("rotate left wrong");  // R4
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (rst)
    ctl.addOp |=> {eReg, acReg} == {1'b0, $past(acReg)} + {1'b0, $past(drData)})
    else $error("add wrong");  // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    !runReg |=> !runReg) else $error("running came back");  // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctl.outOp |=> $stable(outReg)) else $error("outChar moved");  // R10
endmodule

// File: rtl/accRegExec.sv
module accRegExec
  import accRegPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OPS_W  = 12,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              opStrobe,
  input  logic [OPS_W-1:0]  opField,
  input  logic              memStrobe,
  input  logic [1:0]        memOp,
  input  logic [DATA_W-1:0] drData,
  input  logic              inStrobe,
  input  logic [CHAR_W-1:0] inChar,
  input  logic              outStrobe,
  output logic [DATA_W-1:0] acOut,
  output logic              eOut,
  output logic [CHAR_W-1:0] outChar,
  output logic              skipReq,
  output logic              haltReq,
  output logic              running
);
  accCtlT ctl;

  accRegCtrl #(.DATA_W(DATA_W), .OPS_W(OPS_W)) uCtrl (
    .clk(clk), .rst(rst), .opStrobe(opStrobe), .opField(opField),
    .memStrobe(memStrobe), .memOp(memOp), .inStrobe(inStrobe),
    .outStrobe(outStrobe), .acVal(acOut), .eVal(eOut), .ctl(ctl),
    .skipReq(skipReq), .haltReq(haltReq)
  );

  accRegData #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) uData (
    .clk(clk), .rst(rst), .ctl(ctl), .drData(drData), .inChar(inChar),
    .acReg(acOut), .eReg(eOut), .outReg(outChar), .runReg(running)
  );
endmodule

// File: tb/sim_accRegExec.sv
module sim_accRegExec;
  logic        clk = 1'b0;
  logic        rst;
  logic        opStrobe, memStrobe, inStrobe, outStrobe;
  logic [11:0] opField;
  logic [1:0]  memOp;
  logic [15:0] drData;
  logic [7:0]  inChar;
  logic [15:0] acOut;
  logic        eOut, skipReq, haltReq, running;
  logic [7:0]  outChar;

  int tests = 0;
  int fails = 0;

  logic [15:0] mAc;
  logic        mE, mRun;
  logic [7:0]  mOut;

  always #4 clk = ~clk;

  accRegExec u0 (
    .clk(clk), .rst(rst), .opStrobe(opStrobe), .opField(opField),
    .memStrobe(memStrobe), .memOp(memOp), .drData(drData),
    .inStrobe(inStrobe), .inChar(inChar), .outStrobe(outStrobe),
    .acOut(acOut), .eOut(eOut), .outChar(outChar),
    .skipReq(skipReq), .haltReq(haltReq), .running(running)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int topBit(input logic [11:0] f);
    int idx = -1;
    for (int i = 0; i < 12; i++) if (f[i]) idx = i;
    return idx;
  endfunction

  // One cycle: drive, check pulses against model, advance model, check state.
  task automatic step(input logic os, input logic [11:0] f, input logic ms,
                      input logic [1:0] mo, input logic [15:0] d,
                      input logic is, input logic [7:0] ch, input logic us,
                      input string tag);
    logic expSkip, expHalt;
    logic [16:0] sum;
    int b;
    @(negedge clk);
    opStrobe = os; opField = f; memStrobe = ms; memOp = mo; drData = d;
    inStrobe = is; inChar = ch; outStrobe = us;
    b = topBit(f);
    expSkip = 1'b0; expHalt = 1'b0;
    if (os) begin
      case (b)
        11: mAc = 16'h0;
        10: mE = 1'b0;
        9:  mAc = ~mAc;
        8:  mE = ~mE;
        7:  begin mAc = {mE, mAc[15:1]}; mE = acOut[0]; end
        6:  begin mAc = {mAc[14:0], mE}; mE = acOut[15]; end
        5:  mAc = mAc + 16'h1;
        4:  expSkip = ~mAc[15];
        3:  expSkip = mAc[15];
        2:  expSkip = (mAc == 16'h0);
        1:  expSkip = ~mE;
        0:  begin expHalt = 1'b1; mRun = 1'b0; end
        default: ;
      endcase
    end else if (ms) begin
      case (mo)
        2'd0: mAc = mAc & d;
        2'd1: begin sum = {1'b0, mAc} + {1'b0, d}; mAc = sum[15:0]; mE = sum[16]; end
        2'd2: mAc = d;
        default: ;
      endcase
    end else if (is) begin
      mAc = {mAc[15:8], ch};
    end else if (us) begin
      mOut = mAc[7:0];
    end
    #1;
    chk({tag, " skip (R5)"}, {31'd0, skipReq}, {31'd0, expSkip});
    chk({tag, " halt (R6)"}, {31'd0, haltReq}, {31'd0, expHalt});
    @(posedge clk);
    #2;
    opStrobe = 0; memStrobe = 0; inStrobe = 0; outStrobe = 0;
    chk({tag, " acc"}, {16'd0, acOut}, {16'd0, mAc});
    chk({tag, " flag"}, {31'd0, eOut}, {31'd0, mE});
    chk({tag, " outChar"}, {24'd0, outChar}, {24'd0, mOut});
    chk({tag, " running"}, {31'd0, running}, {31'd0, mRun});
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst = 1'b1; opStrobe = 0; opField = 0; memStrobe = 0; memOp = 0;
    drData = 0; inStrobe = 0; inChar = 0; outStrobe = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pulses", {30'd0, skipReq, haltReq}, 32'd0);
    @(negedge clk); rst = 1'b0;
    mAc = 0; mE = 0; mRun = 1; mOut = 0;
    #1;
    chk("R1 reset acc", {16'd0, acOut}, 32'd0);
    chk("R1 reset flag", {31'd0, eOut}, 32'd0);
    chk("R1 reset running", {31'd0, running}, 32'd1);
    chk("R1 reset outChar", {24'd0, outChar}, 32'd0);

    // Directed corners
    step(0, 0, 1, 2'd2, 16'hFFFF, 0, 0, 0, "R8 load");
    step(0, 0, 1, 2'd1, 16'h0001, 0, 0, 0, "R8 add carry");
    step(1, 12'h004, 0, 0, 0, 0, 0, 0, "R5 zero test");
    step(1, 12'h002, 0, 0, 0, 0, 0, 0, "R5 flag test");
    step(1, 12'h080, 0, 0, 0, 0, 0, 0, "R3 rotate right");
    step(1, 12'h040, 0, 0, 0, 0, 0, 0, "R4 rotate left");
    step(1, 12'h100, 0, 0, 0, 0, 0, 0, "R2 complement flag");
    step(1, 12'h080, 0, 0, 0, 0, 0, 0, "R3 rotate right flag in");
    step(1, 12'h010, 0, 0, 0, 0, 0, 0, "R5 positive test");
    step(1, 12'h008, 0, 0, 0, 0, 0, 0, "R5 negative test");
    step(1, 12'h200, 0, 0, 0, 0, 0, 0, "R2 complement acc");
    step(1, 12'h020, 0, 0, 0, 0, 0, 0, "R2 increment");
    step(0, 0, 1, 2'd2, 16'hFFFF, 0, 0, 0, "R8 load ones");
    step(1, 12'h020, 0, 0, 0, 0, 0, 0, "R2 increment wrap");
    step(1, 12'h03C, 0, 0, 0, 0, 0, 0, "R7 multi-bit picks B5");
    step(1, 12'hC01, 0, 0, 0, 0, 0, 0, "R7 multi-bit picks B11");
    step(1, 12'h000, 1, 2'd2, 16'h1234, 1, 8'hAA, 1, "R7 empty field, R11 blocks lower");
    step(0, 0, 1, 2'd3, 16'h5555, 1, 8'h77, 0, "R8 code 3, R11 blocks input");
    step(0, 0, 1, 2'd2, 16'hA5C3, 0, 0, 0, "R8 load pattern");
    step(0, 0, 1, 2'd0, 16'h0FF0, 1, 8'h11, 1, "R8 and");
    step(0, 0, 0, 0, 0, 1, 8'h3C, 1, "R9 input, R11 blocks output");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R10 output");
    step(1, 12'h800, 0, 0, 0, 0, 0, 0, "R2 clear acc");
    step(1, 12'h400, 0, 0, 0, 0, 0, 0, "R2 clear flag");
    step(1, 12'h001, 0, 0, 0, 0, 0, 0, "R6 halt");
    step(0, 0, 1, 2'd2, 16'h00F0, 0, 0, 0, "R6 ops run while halted");

    // Constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] f;
      logic [3:0] k;
      k = 4'($urandom % 16);
      if (k < 12) f = 12'h1 << k;
      else f = 12'($urandom);
      if (n == 1500) begin
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        mAc = 0; mE = 0; mRun = 1; mOut = 0;
      end
      step(($urandom % 3) == 0, (($urandom % 8) == 0) ? f | 12'h001 : f & 12'hFFE,
           ($urandom % 2) == 0, 2'($urandom), 16'($urandom),
           ($urandom % 2) == 0, 8'($urandom), ($urandom % 2) == 0,
           "R2-mix random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule